// File: doc/BRIEF.md
# DRAM Refresh and Power-Down Sequencer

This controller-side block keeps a four-bank DDR DRAM refreshed and manages its clock-enable line. A free-running interval timer builds up a count of refreshes that are owed. The sequencer pays that count off by pulsing an auto-refresh request. If a bank still has a row open when a refresh is to be paid, it first pulses a precharge-all request and waits for the bank status to show every bank idle. While the host reports itself busy, refreshes are held back, up to a fixed limit. Once that limit is reached, the next refresh goes ahead of host traffic.

The same block drives clock enable for the low-power modes. A power-down request drops clock enable. The mode reported depends on the live bank state at that moment: precharge power-down when all banks are idle, active power-down when any row is open. A self-refresh request is honoured only with every bank idle. While self refresh is in effect, the device keeps itself refreshed, so the interval timer is parked and the refresh debt is cleared. Leaving self refresh is asynchronous: a wake input raises clock enable at once, without waiting for a clock edge. The internal state follows after the wake has passed through a two-flop synchroniser. All other mode changes take effect on a rising clock edge.

Top module: `dram_pwr_seq`

## Requirements
- R1: With the host idle and all banks idle, the block gives exactly one single-cycle `ref_req` pulse per `REF_INTERVAL` clock cycles (default 1302, which is 7.8 us at 6 ns). The first pulse follows the rising edge `REF_INTERVAL`+1 after reset.
- R2: When a refresh is due and any bit of `bank_open` is 1, the block gives one `pcall_req` pulse and then no further `pcall_req` while it waits. `ref_req` is never high in the cycle after `bank_open` was sampled nonzero. `ref_req` and `pcall_req` are never high together.
- R3: While `host_busy` is 1, owed refreshes are postponed until `MAX_POSTPONE` (default 8) are owed. At that count a refresh is issued even though `host_busy` is still 1. After `host_busy` falls, the backlog is paid off at one refresh per cycle.
- R4: Outside self refresh, `cke` is 1 in every cycle after a rising edge that sampled `burst_pending` high. Power-down is not entered during a burst, and an active burst request pulls the block out of power-down.
- R5: `lp_mode` encodes 0 = running, 1 = precharge power-down, 2 = active power-down, 3 = self refresh. A `pd_req` sampled with no burst pending and no refresh owed drops `cke` at that edge. `lp_mode` becomes 1 if all banks are idle and 2 otherwise.
- R6: Power-down ends at the rising edge that samples `pd_req` low, or that finds a refresh owed. At that edge `cke` returns to 1 and `lp_mode` returns to 0.
- R7: Self refresh is entered only when all banks are idle, and it takes priority over `pd_req`. A `sr_req` with a bank open is ignored. Once in self refresh, dropping `sr_req` or changing `pd_req` does not leave the mode.
- R8: In self refresh, `cke` goes to 1 as soon as `sr_wake_async` goes high, with no clock edge needed. `lp_mode` stays 3 for two further rising edges and returns to 0 on the third rising edge after the wake.
- R9: No `ref_req` is issued during self refresh, and the refresh debt is cleared. After exit, the next refresh comes `REF_INTERVAL`+1 edges after the exit edge.
- R10: During and immediately after reset, `cke` is 1, `lp_mode` is 0 and both request pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_open | input | NBANK | One bit per bank, 1 = a row is open |
| host_busy | input | 1 | Host traffic is waiting; postpone refresh if allowed |
| burst_pending | input | 1 | A read or write burst is in progress or queued |
| pd_req | input | 1 | Request to enter power-down |
| sr_req | input | 1 | Request to enter self refresh |
| sr_wake_async | input | 1 | Asynchronous self-refresh wake |
| ref_req | output | 1 | Single-cycle auto-refresh command request |
| pcall_req | output | 1 | Single-cycle precharge-all command request |
| cke | output | 1 | DRAM clock enable |
| lp_mode | output | 2 | Current low-power mode (encoding in R5) |

## Verification
The bench targets these corner cases:
- Power-down taken with an open row. A design that reads a stale or wrong bank state would report precharge power-down there.
- A burst arriving during power-down. A design that ignores it would leave clock enable low under live traffic.
- A self-refresh request made with a bank open. A design that honours it would corrupt the open row's data.
- The postponement limit. An off-by-one would issue the forced refresh one interval early or late, so the bench counts pulses across that boundary.
- Self-refresh exit. The bench checks that clock enable rises before any clock edge, and that the mode is released exactly on the third edge after the wake. A design that does not synchronise the wake, or uses the wrong number of flops, misses that edge.
- The precharge-then-refresh path with the bank kept open for a long time. A design that re-sends precharge-all, or refreshes before the banks close, is caught there.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [1:0] {
    LP_NONE   = 2'd0,
    LP_PRE_PD = 2'd1,
    LP_ACT_PD = 2'd2,
    LP_SELF   = 2'd3
  } lp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_PD   = 2'd2,
    ST_SR   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/dps_wake_sync.sv
module dps_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = sh_q[STAGES-1];

endmodule

// File: rtl/dps_ref_timer.sv
module dps_ref_timer #(
  parameter int REF_INTERVAL = 1302,
  parameter int MAX_POSTPONE = 8,
  localparam int TMR_W  = $clog2(REF_INTERVAL),
  localparam int OWED_W = $clog2(MAX_POSTPONE + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              ref_done,
  output logic [OWED_W-1:0] owed
);

  localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(REF_INTERVAL - 1);
  localparam logic [OWED_W-1:0] OWED_CAP = OWED_W'(MAX_POSTPONE + 1);

  logic [TMR_W-1:0]  tmr_q;
  logic [OWED_W-1:0] owed_q;
  logic              tick;

  assign tick = (tmr_q == TMR_LAST);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      tmr_q  <= '0;
      owed_q <= '0;
    end else begin
      tmr_q <= tick ? '0 : tmr_q + 1'b1;
      case ({tick, ref_done})
        2'b10:   if (owed_q < OWED_CAP) owed_q <= owed_q + 1'b1;
        2'b01:   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  assign owed = owed_q;

  // R9: parking the timer clears the debt
  p_sr_clear_r9: assert property (@(posedge clk) disable iff (rst)
    hold |=> (owed_q == '0));

  // R1: a paid refresh never underflows the debt
  p_no_underflow_r1: assert property (@(posedge clk) disable iff (rst)
    (ref_done && !hold) |-> (owed_q != '0));

endmodule

// File: rtl/dps_ctrl_fsm.sv
module dps_ctrl_fsm
  import dps_pkg::*;
#(
  parameter int NBANK        = 4,
  parameter int MAX_POSTPONE = 8,
  localparam int OWED_W      = $clog2(MAX_POSTPONE + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBANK-1:0]  bank_open,
  input  logic              host_busy,
  input  logic              burst_pending,
  input  logic              pd_req,
  input  logic              sr_req,
  input  logic              wake,
  input  logic [OWED_W-1:0] owed,
  output logic              issue_ref,
  output logic              ref_q,
  output logic              pcall_q,
  output logic              cke_q,
  output logic [1:0]        lp_q,
  output logic              in_sr
);

  localparam logic [OWED_W-1:0] OWED_FORCE = OWED_W'(MAX_POSTPONE);

  seq_state_e st_q, st_d;
  lp_mode_e   lp_r, lp_d;
  logic       cke_d, issue_pc;
  logic       any_open, due, forced, go_ref;

  assign any_open = |bank_open;
  assign due      = (owed != '0);
  assign forced   = (owed >= OWED_FORCE);
  assign go_ref   = due && !burst_pending && (!host_busy || forced);

  always_comb begin
    st_d      = st_q;
    lp_d      = lp_r;
    cke_d     = cke_q;
    issue_ref = 1'b0;
    issue_pc  = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (go_ref) begin
          if (any_open) begin
            issue_pc = 1'b1;
            st_d     = ST_WAIT;
          end else begin
            issue_ref = 1'b1;
          end
        end else if (sr_req && !any_open && !burst_pending && !wake) begin
          st_d  = ST_SR;
          cke_d = 1'b0;
          lp_d  = LP_SELF;
        end else if (pd_req && !burst_pending && !due) begin
          st_d  = ST_PD;
          cke_d = 1'b0;
          lp_d  = any_open ? LP_ACT_PD : LP_PRE_PD;
        end
      end
      ST_WAIT: begin
        if (!any_open) begin
          issue_ref = 1'b1;
          st_d      = ST_RUN;
        end
      end
      ST_PD: begin
        if (!pd_req || burst_pending || due) begin
          st_d  = ST_RUN;
          cke_d = 1'b1;
          lp_d  = LP_NONE;
        end
      end
      default: begin
        if (wake) begin
          st_d  = ST_RUN;
          cke_d = 1'b1;
          lp_d  = LP_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_RUN;
      lp_r    <= LP_NONE;
      cke_q   <= 1'b1;
      ref_q   <= 1'b0;
      pcall_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      lp_r    <= lp_d;
      cke_q   <= cke_d;
      ref_q   <= issue_ref;
      pcall_q <= issue_pc;
    end
  end

  assign lp_q  = lp_r;
  assign in_sr = (st_q == ST_SR);

  // R4: clock enable stays high after a burst is seen
  p_cke_burst_r4: assert property (@(posedge clk) disable iff (rst)
    (burst_pending && st_q != ST_SR) |=> cke_q);

  // R2: no refresh straight after an open bank was seen
  p_ref_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (|bank_open) |=> !ref_q);

  // R2: the two command pulses are exclusive
  p_cmd_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(ref_q && pcall_q));

  // R7: self refresh only begins from an all-idle sample
  p_sr_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lp_r == LP_SELF) |-> ($past(bank_open) == '0));

  // R3: at the postponement limit a refresh step is taken
  p_force_r3: assert property (@(posedge clk) disable iff (rst)
    (owed == OWED_FORCE && st_q == ST_RUN && !burst_pending) |=> (ref_q || pcall_q));

  // R5: a low clock enable always has a low-power mode behind it
  p_lowmode_r5: assert property (@(posedge clk) disable iff (rst)
    !cke_q |-> (lp_r != LP_NONE));

endmodule

// File: rtl/dram_pwr_seq.sv
module dram_pwr_seq #(
  parameter int NBANK        = 4,
  parameter int REF_INTERVAL = 1302,
  parameter int MAX_POSTPONE = 8,
  parameter int SYNC_STAGES  = 2,
  localparam int OWED_W      = $clog2(MAX_POSTPONE + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBANK-1:0] bank_open,
  input  logic             host_busy,
  input  logic             burst_pending,
  input  logic             pd_req,
  input  logic             sr_req,
  input  logic             sr_wake_async,
  output logic             ref_req,
  output logic             pcall_req,
  output logic             cke,
  output logic [1:0]       lp_mode
);

  logic              wake_s;
  logic              issue_ref;
  logic              in_sr;
  logic              cke_q;
  logic [OWED_W-1:0] owed;

  dps_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (sr_wake_async),
    .q_sync  (wake_s)
  );

  dps_ref_timer #(
    .REF_INTERVAL (REF_INTERVAL),
    .MAX_POSTPONE (MAX_POSTPONE)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .hold     (in_sr),
    .ref_done (issue_ref),
    .owed     (owed)
  );

  dps_ctrl_fsm #(
    .NBANK        (NBANK),
    .MAX_POSTPONE (MAX_POSTPONE)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .bank_open     (bank_open),
    .host_busy     (host_busy),
    .burst_pending (burst_pending),
    .pd_req        (pd_req),
    .sr_req        (sr_req),
    .wake          (wake_s),
    .owed          (owed),
    .issue_ref     (issue_ref),
    .ref_q         (ref_req),
    .pcall_q       (pcall_req),
    .cke_q         (cke_q),
    .lp_q          (lp_mode),
    .in_sr         (in_sr)
  );

  // self-refresh exit does not wait for a clock edge
  assign cke = cke_q | (in_sr & sr_wake_async);

endmodule

// File: tb/tb_dram_pwr_seq.sv
module tb_dram_pwr_seq;

  localparam int N   = 64;
  localparam int MXP = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] bank_open;
  logic       host_busy, burst_pending, pd_req, sr_req, sr_wake_async;
  logic       ref_req, pcall_req, cke;
  logic [1:0] lp_mode;

  int checks = 0;
  int fails  = 0;
  int nref   = 0;
  int npc    = 0;
  logic prev_burst = 1'b0;
  logic prev_open  = 1'b0;
  logic finished   = 1'b0;

  always #10 clk = ~clk;

  dram_pwr_seq #(.NBANK(4), .REF_INTERVAL(N), .MAX_POSTPONE(MXP)) dut (
    .clk(clk), .rst(rst), .bank_open(bank_open), .host_busy(host_busy),
    .burst_pending(burst_pending), .pd_req(pd_req), .sr_req(sr_req),
    .sr_wake_async(sr_wake_async), .ref_req(ref_req), .pcall_req(pcall_req),
    .cke(cke), .lp_mode(lp_mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pulse counting and continuous rules, sampled away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      if (ref_req) nref++;
      if (pcall_req) npc++;
      if (prev_burst && lp_mode != 2'd3 && !cke) begin
        checks++; fails++;
        $display("FAIL R4 cke after burst actual=%0d expected=1", cke);
      end
      if (ref_req && prev_open) begin
        checks++; fails++;
        $display("FAIL R2 ref with open bank actual=1 expected=0");
      end
      if (ref_req && pcall_req) begin
        checks++; fails++;
        $display("FAIL R2 both pulses actual=1 expected=0");
      end
    end
  end

  always @(posedge clk) begin
    prev_burst <= burst_pending;
    prev_open  <= |bank_open;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bank_open = '0; host_busy = 0; burst_pending = 0;
    pd_req = 0; sr_req = 0; sr_wake_async = 0;
    cyc(3);
    chk("R10 cke in reset", cke, 1);
    chk("R10 mode in reset", lp_mode, 0);
    rst = 1'b0;
    nref = 0; npc = 0;
  endtask

  // {bank[3:0], burst, pd, sr, exp_cke, exp_mode[1:0]}
  localparam logic [9:0] VEC [0:15] = '{
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
    {4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    {4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    {4'b0000, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
    {4'b0010, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2},
    {4'b0010, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
    {4'b0000, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0},
    {4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
    {4'b0100, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0},
    {4'b0100, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2},
    {4'b0100, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0},
    {4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3},
    {4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3}
  };

  initial begin
    int base;
    do_reset();
    chk("R10 cke after reset", cke, 1);
    chk("R10 mode after reset", lp_mode, 0);
    chk("R10 no pulses after reset", ref_req + pcall_req, 0);

    // table: power-down and self-refresh entry/exit (R4 R5 R6 R7)
    for (int i = 0; i < 16; i++) begin
      {bank_open, burst_pending, pd_req, sr_req} = VEC[i][9:3];
      cyc(1);
      chk($sformatf("R5/R6/R7 step %0d cke", i), cke, VEC[i][2]);
      chk($sformatf("R5/R6/R7 step %0d mode", i), lp_mode, VEC[i][1:0]);
    end

    // R8: asynchronous wake, then three-edge release
    pd_req = 0; sr_req = 0;
    #5 sr_wake_async = 1'b1;
    #1 chk("R8 cke rises before edge", cke, 1);
    chk("R8 mode still self refresh", lp_mode, 3);
    cyc(1); chk("R8 mode after edge 1", lp_mode, 3);
    cyc(1); chk("R8 mode after edge 2", lp_mode, 3);
    cyc(1); chk("R8 mode after edge 3", lp_mode, 0);
    chk("R8 cke after release", cke, 1);
    sr_wake_async = 1'b0;

    // R1: periodic refresh
    do_reset();
    cyc(N / 2);
    chk("R1 no early refresh", nref, 0);
    cyc(5 * N);
    chk("R1 five intervals", nref, 5);
    chk("R1 no precharge when idle", npc, 0);

    // R2: open bank forces precharge-all first
    do_reset();
    bank_open = 4'b0001;
    cyc(N + N / 2);
    chk("R2 one precharge-all", npc, 1);
    chk("R2 no refresh while open", nref, 0);
    cyc(N);
    chk("R2 no repeated precharge-all", npc, 1);
    chk("R2 still no refresh", nref, 0);
    bank_open = '0;
    cyc(3);
    chk("R2 both owed refreshes paid", nref, 2);

    // R3: postponement limit
    do_reset();
    host_busy = 1'b1;
    cyc(7 * N + N / 2);
    chk("R3 postponed while busy", nref, 0);
    cyc(N);
    chk("R3 forced at limit", nref, 1);
    host_busy = 1'b0;
    cyc(20);
    chk("R3 backlog drained", nref, 8);

    // R6: owed refresh pulls out of power-down
    do_reset();
    pd_req = 1'b1;
    cyc(3);
    chk("R6 in precharge power-down", lp_mode, 1);
    cyc(N + N / 2);
    chk("R6 refresh taken from power-down", nref, 1);
    chk("R6 back in power-down", lp_mode, 1);
    pd_req = 1'b0;
    cyc(1);
    chk("R6 exit on pd_req low", lp_mode, 0);

    // R9: no refresh during self refresh, restart at exit
    do_reset();
    sr_req = 1'b1;
    cyc(2);
    sr_req = 1'b0;
    chk("R9 in self refresh", lp_mode, 3);
    chk("R9 cke low", cke, 0);
    cyc(3 * N);
    chk("R9 no refresh in self refresh", nref, 0);
    sr_wake_async = 1'b1;
    cyc(3);
    sr_wake_async = 1'b0;
    chk("R9 exited", lp_mode, 0);
    base = nref;
    cyc(N - 2);
    chk("R9 interval restarted", nref - base, 0);
    cyc(N / 2);
    chk("R9 first refresh after exit", nref - base, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule